// File: doc/BRIEF.md
# Squashable Instruction Queue with Register Credits

This block sits between instruction fetch and dispatch and holds fetched instructions in program order. Each entry carries a sequence number and the number of destination registers the instruction will claim. Fetch offers up to a fixed number of instructions per cycle at the tail. Dispatch removes one entry from the head for each request.

Alongside the queue, the block keeps a signed count of free physical registers. Accepted instructions draw from it, and retirement returns registers to it. A squash removes the younger part of the queue and returns the registers those entries held. When the count drops to zero or below, the block raises a rename stall and refuses new instructions until the count is positive again.

Two running statistics are exported: the sum of the occupancy over all cycles, and the number of cycles the queue was completely full.

Top module: `squash_iq`

## Requirements
- R1: After reset the queue is empty, `free_cnt` equals PREGS, `rename_blk` is 0, and both statistics are 0.
- R2: In a cycle with no squash and no rename stall, `enq_acc` equals the smallest of `enq_num`, ENQ_W and DEPTH minus `occ`. Lane i (bits i*SEQ_W and i*DST_W upward) is accepted when i < `enq_acc`, and accepted entries leave in lane order after all older entries.
- R3: With `deq_req` high and a non-empty queue, `deq_vld` is 1 in the same cycle and `deq_seq`/`deq_dst` show the oldest entry, which is removed at the next edge. With an empty queue, `deq_vld` is 0 and `occ` is unchanged.
- R4: When `sq_vld` is high, entries are removed starting from the youngest, for as long as the youngest remaining sequence number is unsigned-greater than `sq_seq`. An entry equal to `sq_seq` stays. `enq_acc` is 0 in that cycle.
- R5: The destination counts of all squashed entries are added back to `free_cnt`.
- R6: Each accepted instruction subtracts its destination count from `free_cnt`.
- R7: Register credits returned by squash and by `ret_free` are added first and the sum is capped at PREGS. Only then is the accepted amount subtracted.
- R8: `rename_blk` is 1 exactly while `free_cnt` <= 0. While it is 1, `enq_acc` is 0.
- R9: Each cycle, `occ_sum` grows by the current `occ`, and `full_cycles` grows by one whenever `occ` equals DEPTH.
- R10: When a squash and a dispatch request fall in the same cycle, the dispatch sees the queue as it stands after the squash. If the squash empties the queue, `deq_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_num | input | $clog2(ENQ_W+2) | Number of instructions offered this cycle |
| enq_seq | input | ENQ_W*SEQ_W | Sequence numbers of the offered lanes |
| enq_dst | input | ENQ_W*DST_W | Destination register counts of the offered lanes |
| enq_acc | output | $clog2(ENQ_W+2) | Number of lanes accepted this cycle |
| deq_req | input | 1 | Dispatch request |
| deq_vld | output | 1 | Dispatch returns an instruction |
| deq_seq | output | SEQ_W | Sequence number of the head entry |
| deq_dst | output | DST_W | Destination count of the head entry |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary sequence number |
| ret_free | input | RET_W | Registers freed by retirement this cycle |
| rename_blk | output | 1 | Rename stall, free count at or below zero |
| free_cnt | output | FREE_W (signed) | Free physical register count |
| occ | output | $clog2(DEPTH+1) | Current occupancy |
| occ_sum | output | ACC_W | Accumulated occupancy |
| full_cycles | output | ACC_W | Cycles spent full |

## Verification
A squash can fall in the same cycle as a dispatch request. It can also coincide with retirement credits that push the free count past its cap. The bench runs phases with a high squash rate, a high dispatch rate and large retirement returns, so all of these overlaps happen many times on a four-entry queue. The squash boundary is picked from the live entries, sometimes exactly on one and sometimes just below it. A queue model in the bench trims younger entries before it judges the same-cycle dispatch, and it caps the credits before it subtracts the accepted counts. Every output is compared with that model each cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;

  // lanes taken this cycle: bounded by the offer, the lane count and free room
  function automatic int unsigned take_count(int unsigned offered, int unsigned lanes,
                                             int unsigned room, logic hold);
    int unsigned t;
    t = offered;
    if (lanes < t) t = lanes;
    if (room < t) t = room;
    return hold ? 0 : t;
  endfunction

  // add credits and clip at the physical register total
  function automatic int cap_add(int cur, int add, int cap);
    int s;
    s = cur + add;
    return (s > cap) ? cap : s;
  endfunction

endpackage

// File: rtl/iq_ring.sv
module iq_ring #(
  parameter int DEPTH = 8,
  parameter int ENQ_W = 2,
  parameter int SEQ_W = 8,
  parameter int DST_W = 2,
  parameter int NUM_W = 2,
  parameter int CNT_W = 4,
  parameter int CR_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sq_vld,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic [NUM_W-1:0]       enq_acc,
  input  logic [ENQ_W*SEQ_W-1:0] enq_seq,
  input  logic [ENQ_W*DST_W-1:0] enq_dst,
  input  logic                   deq_req,
  output logic [CNT_W-1:0]       occ_q,
  output logic                   deq_vld,
  output logic [SEQ_W-1:0]       deq_seq,
  output logic [DST_W-1:0]       deq_dst,
  output logic [CR_W-1:0]        sq_credit
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [DST_W-1:0] dst_mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail;
  logic [CNT_W-1:0] keep;
  logic             still;
  logic [PTR_W-1:0] idx;

  // walk from the youngest entry toward the head while entries are younger
  always_comb begin
    keep      = occ_q;
    sq_credit = '0;
    still     = 1'b1;
    idx       = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      idx = head_q + PTR_W'(k);
      if (sq_vld && still && (CNT_W'(k) < occ_q)) begin
        if (seq_mem[idx] > sq_seq) begin
          keep      = CNT_W'(k);
          sq_credit = sq_credit + CR_W'(dst_mem[idx]);
        end else begin
          still = 1'b0;
        end
      end
    end
  end

  assign deq_vld = deq_req && (keep != '0);
  assign deq_seq = seq_mem[head_q];
  assign deq_dst = dst_mem[head_q];
  assign tail    = head_q + keep[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_q + PTR_W'(deq_vld);
      occ_q  <= keep - CNT_W'(deq_vld) + CNT_W'(enq_acc);
    end
  end

  generate
    for (genvar i = 0; i < ENQ_W; i++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst_n && (NUM_W'(i) < enq_acc)) begin
          seq_mem[tail + PTR_W'(i)] <= enq_seq[i*SEQ_W +: SEQ_W];
          dst_mem[tail + PTR_W'(i)] <= enq_dst[i*DST_W +: DST_W];
        end
      end
    end
  endgenerate

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH));

  // R4
  squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |=> occ_q <= $past(occ_q));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq_vld && occ_q == '0 && enq_acc == '0) |=> (occ_q == '0 && $stable(head_q)));

endmodule

// File: rtl/iq_credit.sv
module iq_credit #(
  parameter int PREGS  = 16,
  parameter int ENQ_W  = 2,
  parameter int DST_W  = 2,
  parameter int NUM_W  = 2,
  parameter int CR_W   = 6,
  parameter int RET_W  = 3,
  parameter int FREE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CR_W-1:0]          sq_credit,
  input  logic [RET_W-1:0]         ret_free,
  input  logic [NUM_W-1:0]         enq_acc,
  input  logic [ENQ_W*DST_W-1:0]   enq_dst,
  output logic signed [FREE_W-1:0] free_q,
  output logic                     blk
);
  localparam int SUM_W = DST_W + $clog2(ENQ_W + 1);

  logic [SUM_W-1:0] enq_sum;
  int               free_nx;

  always_comb begin
    enq_sum = '0;
    for (int i = 0; i < ENQ_W; i++)
      if (NUM_W'(i) < enq_acc) enq_sum = enq_sum + SUM_W'(enq_dst[i*DST_W +: DST_W]);
  end

  always_comb
    free_nx = iq_pkg::cap_add(int'(free_q), int'(sq_credit) + int'(ret_free), PREGS)
              - int'(enq_sum);

  assign blk = (free_q <= 0);

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= FREE_W'(PREGS);
    else        free_q <= FREE_W'(free_nx);
  end

  // R7
  free_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= FREE_W'(PREGS));

  // R8
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> free_q >= $past(free_q));

endmodule

// File: rtl/iq_stats.sv
module iq_stats #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occ_q,
  output logic [ACC_W-1:0] occ_sum,
  output logic [ACC_W-1:0] full_cycles
);
  logic at_full;
  assign at_full = (occ_q == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_sum     <= '0;
      full_cycles <= '0;
    end else begin
      occ_sum     <= occ_sum + ACC_W'(occ_q);
      full_cycles <= full_cycles + ACC_W'(at_full);
    end
  end

  // R9
  occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occ_sum == $past(occ_sum) + ACC_W'($past(occ_q)));

  // R9
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == CNT_W'(DEPTH)) |=> full_cycles == $past(full_cycles) + 1'b1);

endmodule

// File: rtl/squash_iq.sv
module squash_iq #(
  parameter int DEPTH  = 8,
  parameter int ENQ_W  = 2,
  parameter int SEQ_W  = 8,
  parameter int DST_W  = 2,
  parameter int PREGS  = 16,
  parameter int RET_W  = 3,
  parameter int ACC_W  = 32,
  parameter int NUM_W  = $clog2(ENQ_W + 2),
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int FREE_W = $clog2(PREGS + 1) + DST_W + $clog2(ENQ_W + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_W-1:0]         enq_num,
  input  logic [ENQ_W*SEQ_W-1:0]   enq_seq,
  input  logic [ENQ_W*DST_W-1:0]   enq_dst,
  output logic [NUM_W-1:0]         enq_acc,
  input  logic                     deq_req,
  output logic                     deq_vld,
  output logic [SEQ_W-1:0]         deq_seq,
  output logic [DST_W-1:0]         deq_dst,
  input  logic                     sq_vld,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic [RET_W-1:0]         ret_free,
  output logic                     rename_blk,
  output logic signed [FREE_W-1:0] free_cnt,
  output logic [CNT_W-1:0]         occ,
  output logic [ACC_W-1:0]         occ_sum,
  output logic [ACC_W-1:0]         full_cycles
);
  localparam int CR_W = DST_W + $clog2(DEPTH + 1);

  logic [CR_W-1:0] sq_credit;

  assign enq_acc = NUM_W'(iq_pkg::take_count(int'(enq_num), ENQ_W,
                                             DEPTH - int'(occ), sq_vld | rename_blk));

  iq_ring #(.DEPTH(DEPTH), .ENQ_W(ENQ_W), .SEQ_W(SEQ_W), .DST_W(DST_W),
            .NUM_W(NUM_W), .CNT_W(CNT_W), .CR_W(CR_W)) ring_i (
    .clk(clk), .rst_n(rst_n), .sq_vld(sq_vld), .sq_seq(sq_seq),
    .enq_acc(enq_acc), .enq_seq(enq_seq), .enq_dst(enq_dst),
    .deq_req(deq_req), .occ_q(occ), .deq_vld(deq_vld),
    .deq_seq(deq_seq), .deq_dst(deq_dst), .sq_credit(sq_credit));

  iq_credit #(.PREGS(PREGS), .ENQ_W(ENQ_W), .DST_W(DST_W), .NUM_W(NUM_W),
              .CR_W(CR_W), .RET_W(RET_W), .FREE_W(FREE_W)) credit_i (
    .clk(clk), .rst_n(rst_n), .sq_credit(sq_credit), .ret_free(ret_free),
    .enq_acc(enq_acc), .enq_dst(enq_dst), .free_q(free_cnt), .blk(rename_blk));

  iq_stats #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ACC_W(ACC_W)) stats_i (
    .clk(clk), .rst_n(rst_n), .occ_q(occ), .occ_sum(occ_sum),
    .full_cycles(full_cycles));

endmodule

// File: tb/squash_iq_tb_top.sv
`timescale 1ns/1ps
module squash_iq_tb_top;
  localparam int DEPTH = 4, ENQ_W = 2, SEQ_W = 16, DST_W = 2, PREGS = 8, RET_W = 3;
  localparam int ACC_W = 24;
  localparam int NUM_W = $clog2(ENQ_W + 2);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int FREE_W = $clog2(PREGS + 1) + DST_W + $clog2(ENQ_W + 1) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_W-1:0] enq_num = '0;
  logic [ENQ_W*SEQ_W-1:0] enq_seq = '0;
  logic [ENQ_W*DST_W-1:0] enq_dst = '0;
  logic [NUM_W-1:0] enq_acc;
  logic deq_req = 1'b0, deq_vld;
  logic [SEQ_W-1:0] deq_seq;
  logic [DST_W-1:0] deq_dst;
  logic sq_vld = 1'b0;
  logic [SEQ_W-1:0] sq_seq = '0;
  logic [RET_W-1:0] ret_free = '0;
  logic rename_blk;
  logic signed [FREE_W-1:0] free_cnt;
  logic [CNT_W-1:0] occ;
  logic [ACC_W-1:0] occ_sum, full_cycles;

  always #2 clk = ~clk;

  squash_iq #(.DEPTH(DEPTH), .ENQ_W(ENQ_W), .SEQ_W(SEQ_W), .DST_W(DST_W),
              .PREGS(PREGS), .RET_W(RET_W), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enq_num(enq_num), .enq_seq(enq_seq),
    .enq_dst(enq_dst), .enq_acc(enq_acc), .deq_req(deq_req), .deq_vld(deq_vld),
    .deq_seq(deq_seq), .deq_dst(deq_dst), .sq_vld(sq_vld), .sq_seq(sq_seq),
    .ret_free(ret_free), .rename_blk(rename_blk), .free_cnt(free_cnt),
    .occ(occ), .occ_sum(occ_sum), .full_cycles(full_cycles));

  int tests = 0, fails = 0;
  int qs[$];
  int qd[$];
  int mfree = PREGS, msum = 0, mfull = 0, next_seq = 100;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 occ", int'(occ), 0);
    chk("R1 free", int'(free_cnt), PREGS);
    chk("R1 blk", int'(rename_blk), 0);
    chk("R1 occ_sum", int'(occ_sum), 0);
    chk("R1 full", int'(full_cycles), 0);

    for (int c = 0; c < 6000; c++) begin
      int ph, num, acc, room, credit, pre, esum, ret;
      int d[ENQ_W];
      bit blk, sq, dq, evld;
      @(negedge clk);
      ph  = (c / 300) % 4;
      num = $urandom_range(0, 3);
      dq  = ($urandom_range(0, 99) < ((ph == 1) ? 80 : (ph == 0) ? 10 : 40));
      sq  = (qs.size() > 0) && ($urandom_range(0, 99) < ((ph == 2) ? 30 : 5));
      ret = (ph == 3) ? $urandom_range(0, 7) : (($urandom_range(0, 9) == 0) ? $urandom_range(1, 4) : 0);
      for (int i = 0; i < ENQ_W; i++) begin
        d[i] = $urandom_range(0, 3);
        enq_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(next_seq + i);
        enq_dst[i*DST_W +: DST_W] = DST_W'(d[i]);
      end
      enq_num = NUM_W'(num);
      deq_req = dq;
      sq_vld  = sq;
      if (sq) begin
        int pick = qs[$urandom_range(0, qs.size() - 1)];
        sq_seq = SEQ_W'(pick - int'($urandom_range(0, 1)));
      end
      ret_free = RET_W'(ret);
      #1;
      pre = qs.size();
      blk = (mfree <= 0);
      chk("R2 occ", int'(occ), pre);
      chk("R5/R6/R7 free", int'(free_cnt), mfree);
      chk("R8 blk", int'(rename_blk), int'(blk));
      chk("R9 occ_sum", int'(occ_sum), msum);
      chk("R9 full", int'(full_cycles), mfull);
      room = DEPTH - pre;
      acc = (sq || blk) ? 0 : ((num < ENQ_W) ? num : ENQ_W);
      if (acc > room) acc = room;
      chk(sq ? "R4 enq_acc" : (blk ? "R8 enq_acc" : "R2 enq_acc"), int'(enq_acc), acc);
      credit = 0;
      if (sq)
        while (qs.size() > 0 && qs[qs.size() - 1] > int'(sq_seq)) begin
          credit += qd[qd.size() - 1];
          void'(qs.pop_back());
          void'(qd.pop_back());
        end
      evld = dq && (qs.size() > 0);
      chk(sq ? "R10 deq_vld" : "R3 deq_vld", int'(deq_vld), int'(evld));
      if (evld) begin
        chk(sq ? "R10 deq_seq" : "R3 deq_seq", int'(deq_seq), qs[0]);
        chk(sq ? "R10 deq_dst" : "R3 deq_dst", int'(deq_dst), qd[0]);
        void'(qs.pop_front());
        void'(qd.pop_front());
      end
      msum += pre;
      if (pre == DEPTH) mfull++;
      esum = 0;
      for (int i = 0; i < acc; i++) begin
        qs.push_back(next_seq + i);
        qd.push_back(d[i]);
        esum += d[i];
      end
      next_seq += acc;
      mfree = mfree + credit + ret;
      if (mfree > PREGS) mfree = PREGS;
      mfree -= esum;
    end
    @(negedge clk);
    #1;
    chk("R9 final occ_sum", int'(occ_sum), msum);
    chk("R4 final occ", int'(occ), qs.size());
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule